// File: doc/BRIEF.md
# Prescaled Timeout Timer

This block measures a response window for a contactless card reader. A programmable prescaler divides the reference clock so that one timer tick lasts 2·P+1 clock cycles, where P is a 12-bit value assembled from a 4-bit high part and an 8-bit low part. A 16-bit reload value, also supplied as two bytes, gives the number of ticks before the window closes.

The timer is armed by the transmitter. When the auto-start flag is set, each end-of-transmission pulse loads the reload value and starts the countdown. When the count reaches zero, a sticky timer interrupt flag is raised. Software lowers the flag by writing a one to it. A stop input freezes the countdown without raising the flag. The live count can be read at any time as two bytes. With P = 0x0A9 and a reload of 0x03E8 on a 13.56 MHz clock, one tick is 25 µs and the window is 25 ms.

Top module: `tmo_timer`

## Requirements
- R1: After reset the count reads 0x0000 and the interrupt flag reads 0.
- R2: While running, the count drops by exactly one every 2·P+1 clock cycles. The first drop comes 2·P+1 cycles after the start edge.
- R3: P is {pre_hi[3:0], pre_lo[7:0]}, so pre_hi supplies bits 11 to 8 and pre_lo supplies bits 7 to 0.
- R4: An end-of-transmission pulse starts the timer only when auto_start is 1. With auto_start at 0, the pulse leaves the count unchanged.
- R5: A start loads the count with {rld_hi, rld_lo} on the start edge, so the loaded value is readable one cycle later.
- R6: For a reload R ≥ 1, the count reaches 0 and the interrupt flag rises on the same edge, R·(2·P+1) cycles after the start edge. After that the count stays at 0 until the next start.
- R7: A start while the timer is running reloads the count and restarts the prescaler phase.
- R8: While stop is high, the count holds its value and the interrupt flag does not rise. After a stop, the count stays frozen until the next start.
- R9: A write with irq_ack_we = 1 and irq_ack_val = 1 clears the flag on that edge. A write with irq_ack_val = 0 leaves the flag set.
- R10: A reload of 0 expires on the first tick, 2·P+1 cycles after the start edge.
- R11: If expiry and a clearing write fall on the same edge, the flag ends up set.
- R12: Stop takes priority over a start on the same edge, and a start takes priority over a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| auto_start | input | 1 | Enables starting on end of transmission |
| pre_hi | input | 4 | Prescaler bits 11..8 |
| pre_lo | input | 8 | Prescaler bits 7..0 |
| rld_hi | input | 8 | Reload value bits 15..8 |
| rld_lo | input | 8 | Reload value bits 7..0 |
| tx_done | input | 1 | One-cycle end-of-transmission pulse |
| stop | input | 1 | Freezes the countdown |
| irq_ack_we | input | 1 | Write strobe for the interrupt flag |
| irq_ack_val | input | 1 | Written value; 1 clears the flag |
| cnt_hi | output | 8 | Live count bits 15..8 |
| cnt_lo | output | 8 | Live count bits 7..0 |
| irq_timer | output | 1 | Sticky timer-expired flag |

## Verification
The hardest case to reach from the ports is a clearing write that lands on the exact edge of expiry. This race decides whether an expiry event is lost. The bench computes the expiry edge as R·(2·P+1) cycles after the start pulse and places the acknowledge write on that edge. It then checks that the flag survives, and that a later write does clear it. Sweeps over small values of P and R check every cycle of the countdown against the arithmetic formula. The ordering cases are covered by restarting and stopping in the middle of a tick period.

// File: rtl/tmo_pkg.sv
package tmo_pkg;

    localparam int unsigned TMO_PRE_W = 12;
    localparam int unsigned TMO_CNT_W = 16;

    typedef enum logic [0:0] {
        TMO_IDLE = 1'b0,
        TMO_RUN  = 1'b1
    } tmo_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic tick;
    } tmo_evt_t;

    // Terminal value of the divider phase counter: period is 2*P+1
    function automatic logic [TMO_PRE_W:0] div_last(input logic [TMO_PRE_W-1:0] p);
        return {p, 1'b0};
    endfunction

endpackage

// File: rtl/tmo_prescaler.sv
module tmo_prescaler #(
    parameter int unsigned PRE_W = tmo_pkg::TMO_PRE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             restart,
    input  logic [PRE_W-1:0] pre,
    output logic             tick
);
    localparam int unsigned PH_W = PRE_W + 1;

    logic [PH_W-1:0] phase_q;
    logic [PH_W-1:0] last;
    logic            at_end;

    assign last   = {pre, 1'b0};
    assign at_end = (phase_q >= last);
    assign tick   = run && !restart && at_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
        end else if (restart || !run || at_end) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end
endmodule

// File: rtl/tmo_downcount.sv
module tmo_downcount
    import tmo_pkg::*;
#(
    parameter int unsigned CNT_W = tmo_pkg::TMO_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  tmo_evt_t         evt,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count,
    output logic             running,
    output logic             expire
);
    tmo_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             last_tick;

    assign last_tick = (cnt_q <= CNT_W'(1));
    assign expire    = (state_q == TMO_RUN) && evt.tick && !evt.stop
                       && !evt.start && last_tick;
    assign count     = cnt_q;
    assign running   = (state_q == TMO_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TMO_IDLE;
            cnt_q   <= '0;
        end else if (evt.stop) begin
            state_q <= TMO_IDLE;
        end else if (evt.start) begin
            state_q <= TMO_RUN;
            cnt_q   <= reload;
        end else if (state_q == TMO_RUN && evt.tick) begin
            if (last_tick) begin
                cnt_q   <= '0;
                state_q <= TMO_IDLE;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end
endmodule

// File: rtl/tmo_irq_flag.sv
module tmo_irq_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic ack_we,
    input  logic ack_val,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (set_i) begin
            flag <= 1'b1;
        end else if (ack_we && ack_val) begin
            flag <= 1'b0;
        end
    end
endmodule

// File: rtl/tmo_timer.sv
module tmo_timer
    import tmo_pkg::*;
#(
    parameter int unsigned PRE_W = tmo_pkg::TMO_PRE_W,
    parameter int unsigned CNT_W = tmo_pkg::TMO_CNT_W,
    localparam int unsigned HI_PRE_W = PRE_W - 8,
    localparam int unsigned HI_CNT_W = CNT_W - 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                auto_start,
    input  logic [HI_PRE_W-1:0] pre_hi,
    input  logic [7:0]          pre_lo,
    input  logic [HI_CNT_W-1:0] rld_hi,
    input  logic [7:0]          rld_lo,
    input  logic                tx_done,
    input  logic                stop,
    input  logic                irq_ack_we,
    input  logic                irq_ack_val,
    output logic [HI_CNT_W-1:0] cnt_hi,
    output logic [7:0]          cnt_lo,
    output logic                irq_timer
);
    tmo_evt_t         evt;
    logic [PRE_W-1:0] pre_val;
    logic [CNT_W-1:0] reload_val;
    logic [CNT_W-1:0] count;
    logic             running;
    logic             tick;
    logic             expire_pulse;

    assign pre_val    = {pre_hi, pre_lo};
    assign reload_val = {rld_hi, rld_lo};
    assign evt.start  = tx_done && auto_start;
    assign evt.stop   = stop;
    assign evt.tick   = tick;

    tmo_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .run     (running),
        .restart (evt.start),
        .pre     (pre_val),
        .tick    (tick)
    );

    tmo_downcount #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .reload  (reload_val),
        .count   (count),
        .running (running),
        .expire  (expire_pulse)
    );

    tmo_irq_flag u_irq (
        .clk     (clk),
        .rst     (rst),
        .set_i   (expire_pulse),
        .ack_we  (irq_ack_we),
        .ack_val (irq_ack_val),
        .flag    (irq_timer)
    );

    assign cnt_hi = count[CNT_W-1:8];
    assign cnt_lo = count[7:0];
endmodule

// File: rtl/tmo_timer_chk.sv
module tmo_timer_chk #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             auto_start,
    input logic             tx_done,
    input logic             stop,
    input logic             irq_ack_we,
    input logic             irq_ack_val,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] reload,
    input logic             expire_pulse,
    input logic             irq_timer
);
    logic start_evt;
    assign start_evt = tx_done && auto_start;

    assert_rise_at_zero_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_timer) |-> (count == '0));

    assert_hold_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (count == '0 && !start_evt) |=> (count == '0));

    assert_stop_freeze_R8: assert property (@(posedge clk) disable iff (rst)
        stop |=> (count == $past(count)) && !$rose(irq_timer));

    assert_step_one_R2: assert property (@(posedge clk) disable iff (rst)
        !start_evt |=> (count == $past(count)) || (count == $past(count) - 1'b1));

    assert_load_R5: assert property (@(posedge clk) disable iff (rst)
        (start_evt && !stop) |=> (count == $past(reload)));

    assert_ack_clears_R9: assert property (@(posedge clk) disable iff (rst)
        (irq_ack_we && irq_ack_val && !expire_pulse) |=> !irq_timer);

    assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        (irq_timer && !(irq_ack_we && irq_ack_val)) |=> irq_timer);
endmodule

bind tmo_timer tmo_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .auto_start   (auto_start),
    .tx_done      (tx_done),
    .stop         (stop),
    .irq_ack_we   (irq_ack_we),
    .irq_ack_val  (irq_ack_val),
    .count        (count),
    .reload       (reload_val),
    .expire_pulse (expire_pulse),
    .irq_timer    (irq_timer)
);

// File: tb/tmo_timer_test.sv
`timescale 1ns/1ps
module tmo_timer_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       auto_start = 1'b0;
    logic [3:0] pre_hi = '0;
    logic [7:0] pre_lo = '0;
    logic [7:0] rld_hi = '0;
    logic [7:0] rld_lo = '0;
    logic       tx_done = 1'b0;
    logic       stop = 1'b0;
    logic       irq_ack_we = 1'b0;
    logic       irq_ack_val = 1'b0;
    logic [7:0] cnt_hi;
    logic [7:0] cnt_lo;
    logic       irq_timer;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    tmo_timer uut (
        .clk(clk), .rst(rst), .auto_start(auto_start),
        .pre_hi(pre_hi), .pre_lo(pre_lo), .rld_hi(rld_hi), .rld_lo(rld_lo),
        .tx_done(tx_done), .stop(stop),
        .irq_ack_we(irq_ack_we), .irq_ack_val(irq_ack_val),
        .cnt_hi(cnt_hi), .cnt_lo(cnt_lo), .irq_timer(irq_timer)
    );

    task automatic chk(input string req, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp_v, $time);
        end
    endtask

    function automatic int cnt_now();
        return int'({cnt_hi, cnt_lo});
    endfunction

    task automatic configure(input int p, input int r);
        auto_start = 1'b1;
        pre_hi = p[11:8];
        pre_lo = p[7:0];
        rld_hi = r[15:8];
        rld_lo = r[7:0];
    endtask

    task automatic ack();
        irq_ack_we = 1'b1; irq_ack_val = 1'b1;
        @(negedge clk);
        irq_ack_we = 1'b0; irq_ack_val = 1'b0;
    endtask

    task automatic pulse_tx();
        tx_done = 1'b1;
        @(negedge clk);
        tx_done = 1'b0;
    endtask

    // Start, then compare every cycle against the arithmetic model
    task automatic run_case(input int p, input int r, input string req);
        int period;
        int texp;
        int ec;
        configure(p, r);
        ack();
        pulse_tx();
        period = 2 * p + 1;
        texp = ((r == 0) ? 1 : r) * period;
        for (int t = 0; t <= texp + 2; t++) begin
            ec = (t >= texp) ? 0 : r - t / period;
            chk({req, " count"}, cnt_now(), ec);
            chk({req, " irq"}, int'(irq_timer), (t >= texp) ? 1 : 0);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset count", cnt_now(), 0);
        chk("R1 reset irq", int'(irq_timer), 0);

        // R2 / R6 / R10 sweep over small prescaler and reload values
        for (int p = 0; p < 4; p++) begin
            run_case(p, 0, "R10");
            run_case(p, 1, "R6");
            run_case(p, 2, "R2");
            run_case(p, 3, "R2");
            run_case(p, 7, "R2");
        end
        // R3 prescaler split: high nibble and low byte
        run_case(12'h100, 2, "R3");
        run_case(12'h0A9, 3, "R3");
        // R5 distinct reload bytes
        run_case(0, 16'h0102, "R5");

        // R4: no start without the auto flag
        ack();
        configure(0, 5);
        auto_start = 1'b0;
        pulse_tx();
        for (int i = 0; i < 8; i++) begin
            chk("R4 count unchanged", cnt_now(), 0);
            @(negedge clk);
        end

        // R7: restart mid-run reloads and restarts the phase
        configure(1, 4);
        pulse_tx();
        repeat (5) @(negedge clk);
        chk("R7 before restart", cnt_now(), 3);
        run_case(1, 2, "R7");

        // R8: stop freezes, no irq, stays frozen after release
        ack();
        configure(1, 5);
        pulse_tx();
        repeat (3) @(negedge clk);
        stop = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 20; i++) begin
            chk("R8 frozen count", cnt_now(), 4);
            chk("R8 no irq", int'(irq_timer), 0);
            if (i == 5) stop = 1'b0;
            @(negedge clk);
        end

        // R12: stop beats start on the same edge
        tx_done = 1'b1; stop = 1'b1;
        @(negedge clk);
        tx_done = 1'b0; stop = 1'b0;
        chk("R12 stop over start", cnt_now(), 4);

        // R11: clearing write on the expiry edge; flag survives
        ack();
        configure(0, 3);
        pulse_tx();
        @(negedge clk);
        @(negedge clk);
        irq_ack_we = 1'b1; irq_ack_val = 1'b1;
        @(negedge clk);
        irq_ack_we = 1'b0; irq_ack_val = 1'b0;
        chk("R11 count at expiry", cnt_now(), 0);
        chk("R11 flag kept", int'(irq_timer), 1);

        // R9: writing 0 keeps the flag, writing 1 clears it
        irq_ack_we = 1'b1; irq_ack_val = 1'b0;
        @(negedge clk);
        irq_ack_we = 1'b0;
        chk("R9 write zero keeps", int'(irq_timer), 1);
        ack();
        chk("R9 write one clears", int'(irq_timer), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule